// File: doc/BRIEF.md
# DMA Channel Arbiter

This block decides which of a set of DMA channels is served next. Every channel drives one request line. Every channel also owns a programmable priority value. A mode input picks one of two policies. In fixed-priority mode, the requesting channel with the largest priority value wins. In round-robin mode, the priority values play no part: the block searches the channels in turn, starting just after the last channel that was granted.

Arbitration takes two cycles. On the first edge the block samples the request lines and records a candidate. On the second edge it issues the grant, but only if the candidate is still requesting. If the candidate has dropped its request, the request counts as spurious: nothing is granted and the block goes back to idle. Once a grant is issued, it stays on the outputs and no new arbitration starts until the transfer engine returns a one-cycle done pulse.

Top module: `dma_chan_arbiter`

## Requirements
- R1: Synchronous reset (rst_n low at an edge) clears grant_valid, loads priority value n into channel n, and sets the round-robin start point to channel 0.
- R2: With rr_mode low, the requesting channel that holds the largest priority value is granted.
- R3: With rr_mode low, when several requesting channels share the largest priority value, the one with the highest channel number is granted.
- R4: With rr_mode high, priority values are ignored. The grant goes to the first requesting channel found by searching upward from the start point and wrapping from channel 15 to channel 0.
- R5: Every grant, in either mode, moves the round-robin start point to the granted channel plus one, where 15 plus one wraps to 0.
- R6: Requests are sampled at the edge where the block is idle. The grant becomes visible on grant_valid and grant_chan right after the next edge.
- R7: If the candidate's request is low at the second arbitration edge, no grant is issued, no other channel is granted in its place, and the start point is unchanged.
- R8: While grant_valid is high and done is low, grant_valid and grant_chan stay unchanged, whatever the request lines do.
- R9: When prio_we is high at an edge, prio_wdata is written as the priority value of channel prio_idx.
- R10: When done is high at an edge while a grant is held, grant_valid is low right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 16 | Per-channel request lines, bit n belongs to channel n |
| rr_mode | input | 1 | 1 selects round-robin, 0 selects fixed priority |
| prio_we | input | 1 | Priority write strobe |
| prio_idx | input | 4 | Channel whose priority value is written |
| prio_wdata | input | 8 | Priority value to write |
| done | input | 1 | Pulse from the transfer engine that ends the held grant |
| grant_valid | output | 1 | A grant is held |
| grant_chan | output | 4 | Granted channel number |

## Verification
The assertions assume that done is only meaningful while a grant is held, and that the request lines and priority values are stable at the idle sampling edge. The bench drives every input on the falling clock edge, so each rising edge sees settled values. It pulses done only after it has seen grant_valid high. It changes priorities only while the block is idle, so every candidate is computed from one consistent set of priority values.

// File: rtl/dma_arb_pkg.sv
// Package: shared FSM state type for the DMA channel arbiter.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package dma_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_BUSY = 2'd2
    } arb_state_t;
endpackage

// File: rtl/dma_arb_prio_bank.sv
// Module: per-channel priority storage.
// Resets channel n to value n. Written one channel at a time.
// Assumes: wr_idx is below N_CH whenever wr_en is high.
module dma_arb_prio_bank #(
    parameter int N_CH   = 16,
    parameter int PRIO_W = 8,
    parameter int IDX_W  = $clog2(N_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [PRIO_W-1:0]        wr_val,
    output logic [N_CH*PRIO_W-1:0]   prio_flat
);
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic [PRIO_W-1:0] value_q;
        // Hold one channel's priority value; the reset value equals the channel number.
        always_ff @(posedge clk) begin
            if (!rst_n)
                value_q <= PRIO_W'(g);
            else if (wr_en && (wr_idx == IDX_W'(g)))
                value_q <= wr_val;
        end
        assign prio_flat[g*PRIO_W +: PRIO_W] = value_q;
    end
endmodule

// File: rtl/dma_arb_fixed_pick.sv
// Module: combinational fixed-priority picker.
// Picks the requesting channel with the largest priority value.
// On a tie, the higher channel number wins.
// Assumes: the caller ignores pick when any_req is low.
module dma_arb_fixed_pick #(
    parameter int N_CH   = 16,
    parameter int PRIO_W = 8,
    parameter int IDX_W  = $clog2(N_CH)
) (
    input  logic [N_CH-1:0]          req,
    input  logic [N_CH*PRIO_W-1:0]   prio_flat,
    output logic                     any_req,
    output logic [IDX_W-1:0]         pick
);
    logic [PRIO_W-1:0] best_val;

    // Scan upward; ">=" lets a later (higher-numbered) equal channel take over.
    always_comb begin
        any_req  = 1'b0;
        pick     = '0;
        best_val = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (req[i] && (!any_req || prio_flat[i*PRIO_W +: PRIO_W] >= best_val)) begin
                any_req  = 1'b1;
                pick     = IDX_W'(i);
                best_val = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/dma_arb_rr_pick.sv
// Module: combinational rotating picker.
// Picks the first requesting channel at or after start, wrapping at N_CH.
// Assumes: start is below N_CH.
module dma_arb_rr_pick #(
    parameter int N_CH  = 16,
    parameter int IDX_W = $clog2(N_CH)
) (
    input  logic [N_CH-1:0]   req,
    input  logic [IDX_W-1:0]  start,
    output logic              any_req,
    output logic [IDX_W-1:0]  pick
);
    // Walk the channels from start, taking the first request found.
    always_comb begin
        any_req = 1'b0;
        pick    = '0;
        for (int k = 0; k < N_CH; k++) begin
            int j;
            j = (int'(start) + k) % N_CH;
            if (!any_req && req[j]) begin
                any_req = 1'b1;
                pick    = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/dma_chan_arbiter.sv
// Module: top of the DMA channel arbiter.
// Runs a two-step arbitration: sample, then confirm. It holds the grant
// until done arrives. A candidate that drops its request before the
// confirm edge is discarded.
// Assumes: done is pulsed only while a grant is held; inputs are synchronous to clk.
module dma_chan_arbiter #(
    parameter int N_CH   = 16,
    parameter int PRIO_W = 8,
    localparam int IDX_W = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   req,
    input  logic              rr_mode,
    input  logic              prio_we,
    input  logic [IDX_W-1:0]  prio_idx,
    input  logic [PRIO_W-1:0] prio_wdata,
    input  logic              done,
    output logic              grant_valid,
    output logic [IDX_W-1:0]  grant_chan
);
    import dma_arb_pkg::*;

    arb_state_t              state_q;
    logic [IDX_W-1:0]        cand_q;
    logic [IDX_W-1:0]        rr_ptr_q;
    logic [N_CH*PRIO_W-1:0]  prio_flat;
    logic                    fx_any, rr_any, sel_any;
    logic [IDX_W-1:0]        fx_pick, rr_pick, sel_pick, cand_next;

    dma_arb_prio_bank #(.N_CH(N_CH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .wr_en(prio_we), .wr_idx(prio_idx),
        .wr_val(prio_wdata), .prio_flat(prio_flat)
    );

    dma_arb_fixed_pick #(.N_CH(N_CH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_fixed (
        .req(req), .prio_flat(prio_flat), .any_req(fx_any), .pick(fx_pick)
    );

    dma_arb_rr_pick #(.N_CH(N_CH), .IDX_W(IDX_W)) u_rr (
        .req(req), .start(rr_ptr_q), .any_req(rr_any), .pick(rr_pick)
    );

    // Choose the active policy's result.
    always_comb begin
        sel_any  = rr_mode ? rr_any  : fx_any;
        sel_pick = rr_mode ? rr_pick : fx_pick;
    end

    // Compute the channel after the candidate, wrapping to 0.
    always_comb begin
        cand_next = (cand_q == IDX_W'(N_CH-1)) ? '0 : cand_q + 1'b1;
    end

    // Arbitration sequencer: sample, confirm or discard, hold until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cand_q   <= '0;
            rr_ptr_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (sel_any) begin
                    cand_q  <= sel_pick;
                    state_q <= ST_ARB;
                end
                ST_ARB: if (req[cand_q]) begin
                    state_q  <= ST_BUSY;
                    rr_ptr_q <= cand_next;
                end else begin
                    state_q  <= ST_IDLE;
                end
                ST_BUSY: if (done) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign grant_valid = (state_q == ST_BUSY);
    assign grant_chan  = cand_q;

    // ---------------- assertions ----------------
    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        assert_fixed_highest_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!rr_mode && req[g]) |-> (prio_flat[g*PRIO_W +: PRIO_W] <= prio_flat[fx_pick*PRIO_W +: PRIO_W]))
            else $error("fixed picker missed a higher priority");
        assert_fixed_tie_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!rr_mode && req[g] && (IDX_W'(g) > fx_pick)) |->
            (prio_flat[g*PRIO_W +: PRIO_W] != prio_flat[fx_pick*PRIO_W +: PRIO_W]))
            else $error("tie not broken toward higher channel");
    end

    assert_rr_requesting_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_mode && rr_any) |-> req[rr_pick])
        else $error("rotating pick is not requesting");

    assert_ptr_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> (rr_ptr_q == ((grant_chan == IDX_W'(N_CH-1)) ? '0 : grant_chan + 1'b1)))
        else $error("start point not moved past grant");

    assert_grant_was_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> ((($past(req) >> grant_chan) & N_CH'(1)) != '0))
        else $error("grant to channel not requesting at confirm edge");

    assert_spurious_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARB && !req[cand_q]) |=> !grant_valid)
        else $error("withdrawn request was granted");

    assert_grant_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !done) |=> (grant_valid && $stable(grant_chan)))
        else $error("grant changed without done");

    assert_done_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && done) |=> !grant_valid)
        else $error("grant survived done");
endmodule

// File: tb/dma_chan_arbiter_tb.sv
module dma_chan_arbiter_tb;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic        rr_mode = 1'b0;
    logic        prio_we = 1'b0;
    logic [3:0]  prio_idx = '0;
    logic [7:0]  prio_wdata = '0;
    logic        done = 1'b0;
    logic        grant_valid;
    logic [3:0]  grant_chan;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dma_chan_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .rr_mode(rr_mode),
        .prio_we(prio_we), .prio_idx(prio_idx), .prio_wdata(prio_wdata),
        .done(done), .grant_valid(grant_valid), .grant_chan(grant_chan)
    );

    // Vector layout: [37] rr_mode, [36:21] req at sampling edge,
    // [20:5] req at confirm edge, [4] expected valid, [3:0] expected channel.
    localparam int NV = 13;
    localparam logic [37:0] VEC [NV] = '{
        {1'b0, 16'h0005, 16'h0005, 1'b1, 4'd2},   // R2 ptr->3
        {1'b0, 16'h8001, 16'h8001, 1'b1, 4'd15},  // R2 ptr->0
        {1'b1, 16'h8001, 16'h8001, 1'b1, 4'd0},   // R4 ptr->1
        {1'b1, 16'h8001, 16'h8001, 1'b1, 4'd15},  // R4 ptr->0
        {1'b1, 16'h0006, 16'h0006, 1'b1, 4'd1},   // R4 ptr->2
        {1'b1, 16'h0006, 16'h0006, 1'b1, 4'd2},   // R5 ptr->3
        {1'b1, 16'h0006, 16'h0006, 1'b1, 4'd1},   // R4 wrap ptr->2
        {1'b0, 16'h0030, 16'h0010, 1'b0, 4'd0},   // R7 winner 5 withdrawn
        {1'b1, 16'h0004, 16'h0000, 1'b0, 4'd0},   // R7 ptr stays 2
        {1'b1, 16'h0004, 16'h0004, 1'b1, 4'd2},   // R7 ptr unchanged ptr->3
        {1'b0, 16'h00FF, 16'h00FF, 1'b1, 4'd7},   // R2 ptr->8
        {1'b1, 16'h00FF, 16'h00FF, 1'b1, 4'd0},   // R5 wrap from 8
        {1'b0, 16'h0011, 16'h0001, 1'b0, 4'd0}    // R7 no substitute
    };

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic write_prio(input int ch, input int val);
        @(negedge clk);
        prio_we = 1'b1; prio_idx = 4'(ch); prio_wdata = 8'(val);
        @(negedge clk);
        prio_we = 1'b0;
    endtask

    // One arbitration round; R6: grant visible after the second edge.
    task automatic round(input bit m, input logic [15:0] a, input logic [15:0] b,
                         input bit ev, input int ec, input string rq);
        @(negedge clk);
        rr_mode = m; req = a;
        @(negedge clk);
        req = b;
        check(grant_valid == 1'b0, "R6 early", int'(grant_valid), 0);
        @(negedge clk);
        check(grant_valid == ev, rq, int'(grant_valid), int'(ev));
        if (ev) check(grant_chan == 4'(ec), rq, int'(grant_chan), ec);
        req = '0;
        if (ev) begin
            done = 1'b1;
            @(negedge clk);
            done = 1'b0;
            check(grant_valid == 1'b0, "R10", int'(grant_valid), 0);
        end
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(grant_valid == 1'b0, "R1 reset", int'(grant_valid), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            round(VEC[v][37], VEC[v][36:21], VEC[v][20:5], VEC[v][4], int'(VEC[v][3:0]),
                  $sformatf("vec%0d", v));
        end

        // R9/R2: raised priority of channel 3 beats channel 15 (ptr -> 4)
        write_prio(3, 200);
        round(1'b0, 16'h8008, 16'h8008, 1'b1, 3, "R9 R2 written priority");
        // R3: equal 200 on channels 3 and 9 (ptr -> 10)
        write_prio(9, 200);
        round(1'b0, 16'h0208, 16'h0208, 1'b1, 9, "R3 tie");

        // R8: grant held while requests change and done stays low (ptr -> 1)
        @(negedge clk); rr_mode = 1'b0; req = 16'h0001;
        @(negedge clk);
        @(negedge clk);
        check(grant_valid && grant_chan == 4'd0, "R8 grant", int'(grant_chan), 0);
        req = 16'hFFFF;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check(grant_valid && grant_chan == 4'd0, "R8 hold", int'(grant_chan), 0);
        end
        req = '0; done = 1'b1;
        @(negedge clk); done = 1'b0;
        check(grant_valid == 1'b0, "R10", int'(grant_valid), 0);

        // R4: priority 250 on channel 2 ignored in rotating mode (ptr 1 -> grant 1)
        write_prio(2, 250);
        round(1'b1, 16'h0006, 16'h0006, 1'b1, 1, "R4 ignores priority");

        // R1: reset during a held grant restores everything
        write_prio(1, 255);
        @(negedge clk); rr_mode = 1'b0; req = 16'h0006;
        @(negedge clk);
        @(negedge clk);
        check(grant_valid && grant_chan == 4'd1, "R2 prio 255", int'(grant_chan), 1);
        req = '0; rst_n = 1'b0;
        @(negedge clk);
        check(grant_valid == 1'b0, "R1 reset clears grant", int'(grant_valid), 0);
        rst_n = 1'b1;
        round(1'b1, 16'h8001, 16'h8001, 1'b1, 0, "R1 pointer at 0");
        round(1'b0, 16'h0006, 16'h0006, 1'b1, 2, "R1 priorities restored");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule